// File: doc/BRIEF.md
# PIO Read-Ahead Prefetch Engine

This block lets a host collect disk data in programmed-I/O mode without paying a full disk-side cycle on every read. Software writes a byte budget into the count register just before it starts collecting data. The write arms the engine. From then on the engine reads 16-bit words from a simplified disk data port by itself and places them in a small channel FIFO.

The host collects the words through a separate read-ahead data port. A read there is served straight from the FIFO. If the FIFO is empty, the port reports not-ready and the host holds its request until a word arrives. A programmable gap sets the spacing of the disk-side strobes. Fetching pauses while the FIFO is full. A status flag goes high once the budget is spent and the FIFO has been drained.

The sequencer has three states:
- `PH_IDLE`: no fetch is pending.
- `PH_SPACE`: the engine waits out the gap, or waits for FIFO room.
- `PH_STROBE`: one disk read cycle.

The transitions are:
- Any state goes to `PH_SPACE` on a nonzero count write.
- Any state goes to `PH_IDLE` on a zero count write.
- `PH_SPACE` goes to `PH_STROBE` when the gap has expired, bytes remain and the FIFO is not full.
- `PH_SPACE` goes to `PH_IDLE` when the gap has expired and no bytes remain.
- `PH_STROBE` always goes to `PH_SPACE`.

Top module: `pio_prefetch_engine`

## Requirements
- R1: After reset, `disk_rd_stb` and `host_ready` are 0 and `pf_done` is 1.
- R2: A cycle with `cnt_wr` high loads the remaining budget from `cnt_wdata` and empties the FIFO. A zero budget produces no disk strobe.
- R3: Every disk strobe not coincident with `cnt_wr` stores that cycle's `disk_rdata`. Host reads return the stored words in strobe order.
- R4: Each strobe consumes 2 bytes of the budget, and a final single byte also takes one strobe. A budget of N bytes therefore yields exactly ceil(N/2) strobes.
- R5: The first strobe comes `cycle_clks`+2 cycles after the count write cycle. While the FIFO has room, consecutive strobes are exactly `cycle_clks`+2 cycles apart. A strobe lasts one cycle.
- R6: No strobe starts while the FIFO holds `FIFO_DEPTH` words. Once a host read frees a slot at cycle p (the gap having expired), the next strobe is at cycle p+2.
- R7: `host_ready` is 1 exactly when the FIFO holds a word and `cnt_wr` is low. A `host_rd` while `host_ready` is 0 removes nothing.
- R8: `pf_done` is 1 exactly when the remaining budget is zero and the FIFO is empty.
- R9: A count write during an active prefetch discards all queued words, including any word strobed in that same cycle, and restarts fetching under the new budget.
- R10: A host read and a disk strobe in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_wr | input | 1 | Write strobe of the byte-count register |
| cnt_wdata | input | 16 | Byte budget written |
| cycle_clks | input | 8 | Extra idle clocks between disk strobes |
| disk_rd_stb | output | 1 | Disk data port read strobe |
| disk_rdata | input | 16 | Disk data word, valid in the strobe cycle |
| host_rd | input | 1 | Host read request on the read-ahead port |
| host_ready | output | 1 | Read-ahead data valid; a read is accepted this cycle |
| host_rdata | output | 16 | Oldest prefetched word |
| pf_done | output | 1 | Budget spent and FIFO drained |

## Verification
Two functions can fall in the same cycle: a disk strobe pushing a word and a host read popping one.

The bench provokes this overlap in two ways. It holds `host_rd` high through a whole prefetch, and it reads at a slow rhythm while the FIFO sits full. It then judges every cycle against a queue-based model of the ordering and occupancy.

A count write landing on a strobe cycle is a second overlap. The bench provokes it by rewriting the budget mid-transfer. The verdict is that the strobed word never appears at the read port.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SPACE,
        PH_STROBE
    } pf_phase_e;
endpackage

// File: rtl/pf_gap_timer.sv
module pf_gap_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left_q <= '0;
        else if (load)           left_q <= load_val;
        else if (left_q != '0)   left_q <= left_q - TW'(1);
    end

    assign expired = (left_q == '0);
endmodule

// File: rtl/pf_word_fifo.sv
module pf_word_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            if (push && !pop)      fill <= fill + CW'(1);
            else if (pop && !push) fill <= fill - CW'(1);
        end
    end

    assign rd_data = mem[rd_ptr];
    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/pf_fetch_fsm.sv
module pf_fetch_fsm
    import pf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             gap_expired,
    input  logic             fifo_full,
    output logic             strobe,
    output logic             push,
    output logic             gap_load,
    output logic             budget_zero
);
    pf_phase_e        phase_q, phase_d;
    logic [CNT_W-1:0] budget_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        if (cnt_wr) begin
            phase_d = (cnt_wdata != '0) ? PH_SPACE : PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:   phase_d = PH_IDLE;
                PH_SPACE: begin
                    if (gap_expired && budget_q == '0)  phase_d = PH_IDLE;
                    else if (gap_expired && !fifo_full) phase_d = PH_STROBE;
                end
                PH_STROBE: phase_d = PH_SPACE;
                default:   phase_d = PH_IDLE;
            endcase
        end
    end

    always_comb begin
        strobe   = (phase_q == PH_STROBE);
        push     = strobe && !cnt_wr;
        gap_load = cnt_wr || strobe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      budget_q <= '0;
        else if (cnt_wr) budget_q <= cnt_wdata;
        else if (strobe) budget_q <= (budget_q > CNT_W'(1)) ? budget_q - CNT_W'(2) : '0;
    end

    assign budget_zero = (budget_q == '0);

    // R2
    budget_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> budget_q == $past(cnt_wdata));
    // R5
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/pio_prefetch_engine.sv
module pio_prefetch_engine #(
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 16,
    parameter int TMR_W      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic [TMR_W-1:0]  cycle_clks,
    output logic              disk_rd_stb,
    input  logic [DATA_W-1:0] disk_rdata,
    input  logic              host_rd,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              pf_done
);
    logic gap_expired, gap_load, push, pop, budget_zero;
    logic f_empty, f_full;

    pf_gap_timer #(.TW(TMR_W)) gap_i (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .load_val(cycle_clks), .expired(gap_expired)
    );

    pf_fetch_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .gap_expired(gap_expired), .fifo_full(f_full), .strobe(disk_rd_stb),
        .push(push), .gap_load(gap_load), .budget_zero(budget_zero)
    );

    pf_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(cnt_wr), .push(push),
        .push_data(disk_rdata), .pop(pop), .rd_data(host_rdata),
        .empty(f_empty), .full(f_full)
    );

    assign host_ready = !f_empty && !cnt_wr;
    assign pop        = host_rd && host_ready;
    assign pf_done    = budget_zero && f_empty;

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_done |-> !disk_rd_stb);
endmodule

// File: tb/pio_prefetch_engine_tb_top.sv
module pio_prefetch_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic [7:0]  cycle_clks = '0;
    logic        disk_rd_stb;
    logic [15:0] disk_rdata = '0;
    logic        host_rd = 1'b0;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic        pf_done;

    int n_cmp = 0, n_bad = 0, cyc = 0, stb_seen = 0;
    logic finished = 1'b0;

    // behavioural reference: phase 0 idle, 1 waiting, 2 strobe
    int m_phase = 0, m_rem = 0, m_wait = 0;
    logic [15:0] m_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_prefetch_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cycle_clks(cycle_clks), .disk_rd_stb(disk_rd_stb), .disk_rdata(disk_rdata),
        .host_rd(host_rd), .host_ready(host_ready), .host_rdata(host_rdata),
        .pf_done(pf_done)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        logic e_stb, e_rdy, e_done;
        int   sz;
        disk_rdata = 16'h5000 + 16'(cyc * 7);
        #1;
        sz     = m_q.size();
        e_stb  = (m_phase == 2);
        e_rdy  = (sz > 0) && !cnt_wr;
        e_done = (m_rem == 0) && (sz == 0);
        check(disk_rd_stb == e_stb, "R5 R6 strobe", disk_rd_stb, e_stb);
        check(host_ready == e_rdy, "R7 ready", host_ready, e_rdy);
        if (e_rdy) check(host_rdata == m_q[0], "R3 R10 data", host_rdata, m_q[0]);
        check(pf_done == e_done, "R8 done", pf_done, e_done);
        if (disk_rd_stb && !cnt_wr) stb_seen++;
        if (cnt_wr) begin
            m_q.delete();
            m_rem   = cnt_wdata;
            m_wait  = cycle_clks;
            m_phase = (cnt_wdata != 0) ? 1 : 0;
        end else begin
            if (m_phase == 2) begin
                m_rem   = (m_rem >= 2) ? m_rem - 2 : 0;
                m_wait  = cycle_clks;
                m_phase = 1;
            end else if (m_phase == 1) begin
                if (m_wait != 0) m_wait--;
                else if (m_rem == 0) m_phase = 0;
                else if (sz < DEPTH) m_phase = 2;
            end
            if (host_rd && e_rdy) void'(m_q.pop_front());
            if (e_stb) m_q.push_back(disk_rdata);
        end
        cyc++;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic arm(input int bytes, input int gap);
        cycle_clks = 8'(gap);
        cnt_wdata  = 16'(bytes);
        cnt_wr     = 1'b1;
        stb_seen   = 0;
        tick();
        cnt_wr = 1'b0;
    endtask

    task automatic run_until_done(input int limit);
        for (int i = 0; i < limit && !(pf_done && m_phase == 0); i++) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check(disk_rd_stb == 1'b0, "R1 stb", disk_rd_stb, 0);
        check(host_ready == 1'b0, "R1 ready", host_ready, 0);
        check(pf_done == 1'b1, "R1 done", pf_done, 1);
        rst_n = 1'b1;
        tick();

        // R10 continuous reads overlap with strobes; R4 even budget
        host_rd = 1'b1;
        arm(8, 2);
        run_until_done(200);
        check(stb_seen == 4, "R4 even count", stb_seen, 4);

        // R6 FIFO fills with no reads, then drains slowly
        host_rd = 1'b0;
        arm(20, 1);
        repeat (40) tick();
        check(stb_seen == DEPTH, "R6 stall at full", stb_seen, DEPTH);
        for (int i = 0; i < 300 && !(pf_done && m_phase == 0); i++) begin
            host_rd = (i % 3 == 0);
            tick();
        end
        host_rd = 1'b0;
        check(stb_seen == 10, "R4 R6 resumed total", stb_seen, 10);

        // R2 zero budget
        arm(0, 0);
        repeat (20) tick();
        check(stb_seen == 0, "R2 zero budget", stb_seen, 0);

        // R4 odd budget, gap 0
        host_rd = 1'b1;
        arm(5, 0);
        run_until_done(100);
        check(stb_seen == 3, "R4 odd count", stb_seen, 3);

        // R9 rewrite mid-transfer, aimed at strobe cycle as well
        host_rd = 1'b0;
        arm(30, 3);
        repeat (12) tick();
        arm(6, 0);
        host_rd = 1'b1;
        run_until_done(100);
        check(stb_seen == 3, "R9 restart count", stb_seen, 3);
        host_rd = 1'b0;
        arm(30, 0);
        for (int i = 0; i < 40 && !disk_rd_stb; i++) tick();
        arm(2, 0);
        host_rd = 1'b1;
        run_until_done(100);
        check(stb_seen == 1, "R9 strobe on write dropped", stb_seen, 1);
        host_rd = 1'b0;
        repeat (4) tick();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule